// File: doc/BRIEF.md
# Address Translation Buffer with Two-Level Table Walker

The block turns virtual addresses into physical addresses. A small, fully associative store keeps recent page-number mappings. A lookup that finds its page answers in the next cycle. A lookup that misses starts a hardware walk through a two-level page table in memory. The walk makes one read per level over a simple request/response read port whose latency may vary. It then writes the leaf mapping into the store and answers the request. While a walk runs, the translate port holds off new requests.

Every answer carries a physical address or a fault. A page fault means an entry without its valid flag was found at either level. A protection fault means the leaf entry does not allow the requested kind of access. The store also keeps per-entry accessed and dirty flags, which each response reports so that a client can see the state the mapping has reached. A flush input drops every cached mapping in a single cycle.

With the default parameters the virtual address is 32 bits and the page is 4 KB. The 20-bit page number splits into a 10-bit first-level index and a 10-bit second-level index. The store has 16 entries, and the first-level table sits at a fixed base address given by a parameter.

Top module: `vxlat_tlb`

## Requirements
- R1: A successful response carries `rsp_paddr_o = {frame, vaddr[11:0]}`: the frame number of the mapping above the untouched page offset.
- R2: A request accepted with `req_valid_i & req_ready_o` whose page is held in the store gives `rsp_valid_o` with `rsp_hit_o=1` in the very next cycle. While no walk is running, requests can be accepted on consecutive cycles.
- R3: On a miss the walker issues two reads. The first is at `ROOT_ADDR + 4*vaddr[31:22]`. The second is at `{l1_frame, 12'h000} + 4*vaddr[21:12]`, where `l1_frame` is bits [31:12] of the first-level entry. The response, with `rsp_hit_o=0`, comes one cycle after the second read's data. `req_ready_o` stays low from the accept until that response.
- R4: A page-table entry is a 32-bit word. Bit 0 is valid, bit 1 allows reads, bit 2 allows writes, bit 3 allows execution, bit 4 is accessed, bit 5 is dirty, and bits [31:12] hold the frame number. Accessed and dirty flags read from a leaf are kept in the refilled entry.
- R5: A valid bit of 0 at either level ends the walk with `rsp_page_fault_o=1`, `rsp_hit_o=0`, a zero address and zero flags. No entry is written, so the same page walks again on its next request.
- R6: The access code is 0 for read, 1 for write, 2 for execute and 3 reserved. An access the entry does not allow, and code 3 always, gives `rsp_prot_fault_o=1` with a zero address, on both the hit path and the walk path.
- R7: A successful walk writes the leaf mapping into the store even when the access faulted on protection, so later requests to that page hit.
- R8: An allowed access sets the entry's accessed flag, and an allowed write also sets its dirty flag. `rsp_accessed_o` and `rsp_dirty_o` report the flags after the access. A faulting access leaves them unchanged.
- R9: A refill takes the lowest-numbered free entry. When every entry is valid, it takes the entry under a round-robin pointer that starts at 0 and advances by one for each such refill.
- R10: A cycle with `flush_i=1` holds `req_ready_o` low and drops every mapping, so the next request to any page walks.
- R11: `mem_req_o` is a one-cycle pulse, and at most one read is outstanding. The read data is taken when `mem_rvalid_i` rises, one or more cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all cached mappings |
| req_valid_i | input | 1 | Translate request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute |
| rsp_valid_o | output | 1 | Response present (one cycle) |
| rsp_paddr_o | output | 32 | Physical address, zero on fault |
| rsp_hit_o | output | 1 | Answered from the store without a walk |
| rsp_page_fault_o | output | 1 | Invalid table entry found |
| rsp_prot_fault_o | output | 1 | Access not allowed by the entry |
| rsp_accessed_o | output | 1 | Entry accessed flag after this access |
| rsp_dirty_o | output | 1 | Entry dirty flag after this access |
| mem_req_o | output | 1 | Page-table read request pulse |
| mem_addr_o | output | 32 | Page-table read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (page-table entry) |

## Verification
A stale or missing mapping shows up at the ports within the same request. A hit turns into a walk, which can be seen as extra reads on the memory port and a late response with the hit flag low. A wrong victim choice shows as a hit where a miss is due, or the reverse, on the next request to the evicted page. A corrupted flag or frame in an entry gives a wrong dirty or accessed bit, or a wrong address, on the next hit to that page, one cycle after the accept. A walker that reads the wrong word is caught by comparing every read address against the expected table location for that request.

// File: rtl/vxlat_pkg.sv
package vxlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  // table entry bit positions
  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_R = 1;
  localparam int unsigned PTE_W = 2;
  localparam int unsigned PTE_X = 3;
  localparam int unsigned PTE_A = 4;
  localparam int unsigned PTE_D = 5;
  localparam int unsigned PTE_FLAG_W = 6;

  function automatic logic perm_ok(acc_e acc, perm_t p);
    case (acc)
      ACC_READ:  return p.r;
      ACC_WRITE: return p.w;
      ACC_EXEC:  return p.x;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vxlat_cam.sv
module vxlat_cam import vxlat_pkg::*; #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [VPN_W-1:0]   lkp_vpn_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [PFN_W-1:0]   hit_pfn_o,
  output perm_t              hit_perm_o,
  output logic               hit_a_o,
  output logic               hit_d_o,
  output logic [ENTRIES-1:0] hit_vec_o,
  output logic [ENTRIES-1:0] valid_vec_o,
  input  logic               touch_en_i,
  input  logic [IDX_W-1:0]   touch_idx_i,
  input  logic               touch_dirty_i,
  input  logic               fill_en_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [PFN_W-1:0]   fill_pfn_i,
  input  perm_t              fill_perm_i,
  input  logic               fill_a_i,
  input  logic               fill_d_i
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic [ENTRIES-1:0] a_q;
  logic [ENTRIES-1:0] d_q;

  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   victim;
  logic               have_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec_o[g] = valid_q[g] && (vpn_q[g] == lkp_vpn_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o       = |hit_vec_o;
  assign hit_pfn_o   = pfn_q[hit_idx_o];
  assign hit_perm_o  = perm_q[hit_idx_o];
  assign hit_a_o     = a_q[hit_idx_o];
  assign hit_d_o     = d_q[hit_idx_o];
  assign valid_vec_o = valid_q;

  // lowest free slot wins, otherwise the round-robin slot
  always_comb begin
    victim    = rr_q;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        victim    = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_en_i && !have_free && !flush_i) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        vpn_q[g]   <= '0;
        pfn_q[g]   <= '0;
        perm_q[g]  <= '0;
        a_q[g]     <= 1'b0;
        d_q[g]     <= 1'b0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (fill_en_i && (victim == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        vpn_q[g]   <= fill_vpn_i;
        pfn_q[g]   <= fill_pfn_i;
        perm_q[g]  <= fill_perm_i;
        a_q[g]     <= fill_a_i;
        d_q[g]     <= fill_d_i;
      end else if (touch_en_i && (touch_idx_i == IDX_W'(g))) begin
        a_q[g] <= 1'b1;
        d_q[g] <= d_q[g] | touch_dirty_i;
      end
    end
  end

endmodule

// File: rtl/vxlat_walk.sv
module vxlat_walk import vxlat_pkg::*; #(
  parameter int unsigned  VPN_W     = 20,
  parameter int unsigned  L1_W      = 10,
  parameter int unsigned  PFN_W     = 20,
  parameter int unsigned  PA_W      = 32,
  parameter int unsigned  DW        = 32,
  parameter logic [31:0]  ROOT_ADDR = 32'h0001_0000,
  localparam int unsigned L2_W      = VPN_W - L1_W,
  localparam int unsigned OFF_W     = PA_W - PFN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [PFN_W-1:0] leaf_pfn_o,
  output perm_t            leaf_perm_o,
  output logic             leaf_a_o,
  output logic             leaf_d_o
);

  typedef enum logic [2:0] {
    W_IDLE, W_L1_REQ, W_L1_WAIT, W_L2_REQ, W_L2_WAIT
  } wstate_e;

  wstate_e           state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PFN_W-1:0]  tbl_q;
  logic [L1_W-1:0]   l1_idx;
  logic [L2_W-1:0]   l2_idx;
  logic              rd_v;
  logic [PFN_W-1:0]  rd_frame;
  logic              unused_pte_bits;

  assign l1_idx   = vpn_q[VPN_W-1 -: L1_W];
  assign l2_idx   = vpn_q[L2_W-1:0];
  assign rd_v     = mem_rdata_i[PTE_V];
  assign rd_frame = mem_rdata_i[DW-1 -: PFN_W];
  assign unused_pte_bits = ^mem_rdata_i[DW-PFN_W-1:PTE_FLAG_W];

  assign busy_o     = (state_q != W_IDLE);
  assign mem_req_o  = (state_q == W_L1_REQ) || (state_q == W_L2_REQ);
  assign mem_addr_o = (state_q == W_L1_REQ)
                    ? PA_W'(ROOT_ADDR) + PA_W'({l1_idx, 2'b00})
                    : {tbl_q, OFF_W'(0)} + PA_W'({l2_idx, 2'b00});

  assign done_o  = mem_rvalid_i &&
                   (((state_q == W_L1_WAIT) && !rd_v) || (state_q == W_L2_WAIT));
  assign fault_o = !rd_v;

  assign leaf_pfn_o  = rd_frame;
  assign leaf_perm_o = '{r: mem_rdata_i[PTE_R], w: mem_rdata_i[PTE_W], x: mem_rdata_i[PTE_X]};
  assign leaf_a_o    = mem_rdata_i[PTE_A];
  assign leaf_d_o    = mem_rdata_i[PTE_D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      vpn_q   <= '0;
      tbl_q   <= '0;
    end else begin
      case (state_q)
        W_IDLE: if (start_i) begin
          vpn_q   <= vpn_i;
          state_q <= W_L1_REQ;
        end
        W_L1_REQ: state_q <= W_L1_WAIT;
        W_L1_WAIT: if (mem_rvalid_i) begin
          if (rd_v) begin
            tbl_q   <= rd_frame;
            state_q <= W_L2_REQ;
          end else begin
            state_q <= W_IDLE;
          end
        end
        W_L2_REQ: state_q <= W_L2_WAIT;
        W_L2_WAIT: if (mem_rvalid_i) state_q <= W_IDLE;
        default: state_q <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vxlat_tlb.sv
module vxlat_tlb import vxlat_pkg::*; #(
  parameter int unsigned  VA_W      = 32,
  parameter int unsigned  OFF_W     = 12,
  parameter int unsigned  L1_W      = 10,
  parameter int unsigned  PFN_W     = 20,
  parameter int unsigned  ENTRIES   = 16,
  parameter int unsigned  PTE_DW    = 32,
  parameter logic [31:0]  ROOT_ADDR = 32'h0001_0000,
  localparam int unsigned VPN_W     = VA_W - OFF_W,
  localparam int unsigned PA_W      = PFN_W + OFF_W,
  localparam int unsigned IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [1:0]        req_acc_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              rsp_hit_o,
  output logic              rsp_page_fault_o,
  output logic              rsp_prot_fault_o,
  output logic              rsp_accessed_o,
  output logic              rsp_dirty_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_DW-1:0] mem_rdata_i
);

  logic               accept;
  acc_e               acc_in;
  acc_e               acc_q;
  logic [OFF_W-1:0]   off_q;
  logic [VPN_W-1:0]   lkp_vpn;

  logic               lkp_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   hit_pfn;
  perm_t              hit_perm;
  logic               hit_a, hit_d, hit_ok;
  logic [ENTRIES-1:0] hit_vec, valid_vec;

  logic               walk_busy, walk_done, walk_fault;
  logic [PFN_W-1:0]   leaf_pfn;
  perm_t              leaf_perm;
  logic               leaf_a, leaf_d, leaf_ok;
  logic               fill_en, fill_a, fill_d;

  assign req_ready_o = !walk_busy && !flush_i;
  assign accept      = req_valid_i && req_ready_o;
  assign acc_in      = acc_e'(req_acc_i);
  assign lkp_vpn     = req_vaddr_i[VA_W-1:OFF_W];
  assign hit_ok      = perm_ok(acc_in, hit_perm);
  assign leaf_ok     = perm_ok(acc_q, leaf_perm);
  assign fill_en     = walk_done && !walk_fault;
  assign fill_a      = leaf_a | leaf_ok;
  assign fill_d      = leaf_d | (leaf_ok && (acc_q == ACC_WRITE));

  vxlat_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_cam (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .lkp_vpn_i     (lkp_vpn),
    .hit_o         (lkp_hit),
    .hit_idx_o     (hit_idx),
    .hit_pfn_o     (hit_pfn),
    .hit_perm_o    (hit_perm),
    .hit_a_o       (hit_a),
    .hit_d_o       (hit_d),
    .hit_vec_o     (hit_vec),
    .valid_vec_o   (valid_vec),
    .touch_en_i    (accept && lkp_hit && hit_ok),
    .touch_idx_i   (hit_idx),
    .touch_dirty_i (acc_in == ACC_WRITE),
    .fill_en_i     (fill_en),
    .fill_vpn_i    (lkp_vpn_walk),
    .fill_pfn_i    (leaf_pfn),
    .fill_perm_i   (leaf_perm),
    .fill_a_i      (fill_a),
    .fill_d_i      (fill_d)
  );

  vxlat_walk #(
    .VPN_W     (VPN_W),
    .L1_W      (L1_W),
    .PFN_W     (PFN_W),
    .PA_W      (PA_W),
    .DW        (PTE_DW),
    .ROOT_ADDR (ROOT_ADDR)
  ) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept && !lkp_hit),
    .vpn_i        (lkp_vpn),
    .busy_o       (walk_busy),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (walk_done),
    .fault_o      (walk_fault),
    .leaf_pfn_o   (leaf_pfn),
    .leaf_perm_o  (leaf_perm),
    .leaf_a_o     (leaf_a),
    .leaf_d_o     (leaf_d)
  );

  // page number of the request being walked
  logic [VPN_W-1:0] lkp_vpn_walk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= ACC_READ;
      off_q        <= '0;
      lkp_vpn_walk <= '0;
    end else if (accept) begin
      acc_q        <= acc_in;
      off_q        <= req_vaddr_i[OFF_W-1:0];
      lkp_vpn_walk <= lkp_vpn;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_paddr_o      <= '0;
      rsp_hit_o        <= 1'b0;
      rsp_page_fault_o <= 1'b0;
      rsp_prot_fault_o <= 1'b0;
      rsp_accessed_o   <= 1'b0;
      rsp_dirty_o      <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept && lkp_hit) begin
        rsp_valid_o      <= 1'b1;
        rsp_hit_o        <= 1'b1;
        rsp_page_fault_o <= 1'b0;
        rsp_prot_fault_o <= !hit_ok;
        rsp_paddr_o      <= hit_ok ? {hit_pfn, req_vaddr_i[OFF_W-1:0]} : '0;
        rsp_accessed_o   <= hit_a | hit_ok;
        rsp_dirty_o      <= hit_d | (hit_ok && (acc_in == ACC_WRITE));
      end else if (walk_done) begin
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= 1'b0;
        if (walk_fault) begin
          rsp_page_fault_o <= 1'b1;
          rsp_prot_fault_o <= 1'b0;
          rsp_paddr_o      <= '0;
          rsp_accessed_o   <= 1'b0;
          rsp_dirty_o      <= 1'b0;
        end else begin
          rsp_page_fault_o <= 1'b0;
          rsp_prot_fault_o <= !leaf_ok;
          rsp_paddr_o      <= leaf_ok ? {leaf_pfn, off_q} : '0;
          rsp_accessed_o   <= fill_a;
          rsp_dirty_o      <= fill_d;
        end
      end
    end
  end

endmodule

// File: rtl/vxlat_tlb_chk.sv
module vxlat_tlb_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PA_W    = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic               rsp_page_fault_o,
  input logic               rsp_prot_fault_o,
  input logic [PA_W-1:0]    rsp_paddr_o,
  input logic               mem_req_o,
  input logic               walk_busy_i,
  input logic               lkp_hit_i,
  input logic [ENTRIES-1:0] hit_vec_i,
  input logic [ENTRIES-1:0] valid_vec_i
);

  assert_hit_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && lkp_hit_i) |=> (rsp_valid_o && rsp_hit_o))
    else $error("hit did not answer in one cycle");

  assert_stall_walk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_busy_i |-> !req_ready_o)
    else $error("request accepted during walk");

  assert_pf_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_page_fault_o) |-> (rsp_paddr_o == '0 && !rsp_hit_o && !rsp_prot_fault_o))
    else $error("page fault response not clean");

  assert_prot_noaddr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_prot_fault_o) |-> (rsp_paddr_o == '0))
    else $error("protection fault carried an address");

  assert_unique_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i))
    else $error("several entries match one page");

  assert_flush_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_vec_i == '0))
    else $error("mapping survived flush");

  assert_req_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o)
    else $error("memory request longer than one cycle");

endmodule

bind vxlat_tlb vxlat_tlb_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .flush_i          (flush_i),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_hit_o        (rsp_hit_o),
  .rsp_page_fault_o (rsp_page_fault_o),
  .rsp_prot_fault_o (rsp_prot_fault_o),
  .rsp_paddr_o      (rsp_paddr_o),
  .mem_req_o        (mem_req_o),
  .walk_busy_i      (walk_busy),
  .lkp_hit_i        (lkp_hit),
  .hit_vec_i        (hit_vec),
  .valid_vec_i      (valid_vec)
);

// File: tb/vxlat_tlb_bench.sv
`timescale 1ns/1ps
module vxlat_tlb_bench;
  localparam int ENTRIES = 16;
  localparam logic [31:0] ROOT = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_paddr_o;
  logic        rsp_hit_o, rsp_page_fault_o, rsp_prot_fault_o, rsp_accessed_o, rsp_dirty_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2 clk = ~clk;

  vxlat_tlb u_vxlat_tlb (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .req_acc_i(req_acc_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_hit_o(rsp_hit_o),
    .rsp_page_fault_o(rsp_page_fault_o), .rsp_prot_fault_o(rsp_prot_fault_o),
    .rsp_accessed_o(rsp_accessed_o), .rsp_dirty_o(rsp_dirty_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  int errors = 0;
  int checks = 0;
  int mem_viol = 0;
  int rd_cnt = 0;

  logic [31:0] pt_mem [int unsigned];
  logic [31:0] rd_q [$];
  logic [31:0] next_tbl = 32'h0002_0000;

  // behavioural translation store
  bit          m_v [ENTRIES];
  logic [19:0] m_vpn [ENTRIES];
  logic [19:0] m_pfn [ENTRIES];
  logic [2:0]  m_rwx [ENTRIES];
  bit          m_a [ENTRIES];
  bit          m_d [ENTRIES];
  int          m_rr = 0;

  bit          e_hit, e_pf, e_prot, e_a, e_d;
  logic [31:0] e_pa;
  logic [31:0] e_rd [2];
  int          e_nrd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdmem(logic [31:0] a);
    return pt_mem.exists(a) ? pt_mem[a] : 32'h0;
  endfunction

  // flags: {d,a,x,w,r}
  task automatic map_page(logic [31:0] va, logic [19:0] pfn, logic [4:0] flags);
    logic [31:0] l1a, l2a, p1;
    l1a = ROOT + {20'h0, va[31:22], 2'b00};
    p1 = rdmem(l1a);
    if (!p1[0]) begin
      p1 = next_tbl | 32'h1;
      pt_mem[l1a] = p1;
      next_tbl = next_tbl + 32'h1000;
    end
    l2a = {p1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    pt_mem[l2a] = {pfn, 6'h0, flags, 1'b1};
  endtask

  function automatic bit allow(logic [1:0] acc, logic [2:0] rwx);
    case (acc)
      2'd0: return rwx[0];
      2'd1: return rwx[1];
      2'd2: return rwx[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model(logic [31:0] va, logic [1:0] acc);
    int idx;
    bit ok;
    logic [31:0] p1, p2;
    idx = -1;
    for (int i = 0; i < ENTRIES; i++) if (m_v[i] && m_vpn[i] == va[31:12]) idx = i;
    e_hit = 0; e_pf = 0; e_prot = 0; e_a = 0; e_d = 0; e_pa = 0; e_nrd = 0;
    if (idx >= 0) begin
      e_hit = 1;
      ok = allow(acc, m_rwx[idx]);
      if (ok) begin
        m_a[idx] = 1;
        if (acc == 2'd1) m_d[idx] = 1;
        e_pa = {m_pfn[idx], va[11:0]};
      end
      e_prot = !ok; e_a = m_a[idx]; e_d = m_d[idx];
    end else begin
      e_rd[0] = ROOT + {20'h0, va[31:22], 2'b00};
      e_nrd = 1;
      p1 = rdmem(e_rd[0]);
      if (!p1[0]) begin
        e_pf = 1;
      end else begin
        e_rd[1] = {p1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        e_nrd = 2;
        p2 = rdmem(e_rd[1]);
        if (!p2[0]) begin
          e_pf = 1;
        end else begin
          idx = -1;
          for (int i = ENTRIES - 1; i >= 0; i--) if (!m_v[i]) idx = i;
          if (idx < 0) begin
            idx = m_rr;
            m_rr = (m_rr + 1) % ENTRIES;
          end
          ok = allow(acc, p2[3:1]);
          m_v[idx] = 1; m_vpn[idx] = va[31:12]; m_pfn[idx] = p2[31:12];
          m_rwx[idx] = p2[3:1];
          m_a[idx] = p2[4] | ok;
          m_d[idx] = p2[5] | (ok && acc == 2'd1);
          e_prot = !ok; e_a = m_a[idx]; e_d = m_d[idx];
          if (ok) e_pa = {p2[31:12], va[11:0]};
        end
      end
    end
  endtask

  task automatic xlat(logic [31:0] va, logic [1:0] acc, string tag);
    int cyc;
    model(va, acc);
    rd_q.delete();
    @(negedge clk);
    req_valid_i = 1; req_vaddr_i = va; req_acc_i = acc;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 0;
    cyc = 1;
    while (!rsp_valid_o && cyc < 200) begin @(negedge clk); cyc++; end
    chk({tag, " rsp_valid"}, 32'(rsp_valid_o), 32'h1);
    chk({tag, " hit"}, 32'(rsp_hit_o), 32'(e_hit));
    chk({tag, " page_fault"}, 32'(rsp_page_fault_o), 32'(e_pf));
    chk({tag, " prot_fault"}, 32'(rsp_prot_fault_o), 32'(e_prot));
    chk({tag, " paddr"}, rsp_paddr_o, e_pa);
    chk({tag, " accessed"}, 32'(rsp_accessed_o), 32'(e_a));
    chk({tag, " dirty"}, 32'(rsp_dirty_o), 32'(e_d));
    chk({tag, " read count"}, 32'(rd_q.size()), 32'(e_nrd));
    for (int i = 0; i < e_nrd && i < rd_q.size(); i++)
      chk({tag, " read addr"}, rd_q[i], e_rd[i]);
    if (e_hit) chk({tag, " hit latency"}, 32'(cyc), 32'h1);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1;
    #1 chk("R10 ready low in flush", 32'(req_ready_o), 32'h0);
    @(negedge clk);
    flush_i = 0;
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
  endtask

  // page-table memory with varying latency
  initial begin
    int lat;
    forever begin
      @(negedge clk);
      mem_rvalid_i = 0;
      if (mem_req_o) begin
        rd_q.push_back(mem_addr_o);
        lat = 1 + (rd_cnt % 3);
        rd_cnt++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (mem_req_o) mem_viol++;
        end
        mem_rvalid_i = 1;
        mem_rdata_i = rdmem(mem_addr_last(rd_q));
      end
    end
  end

  function automatic logic [31:0] mem_addr_last(logic [31:0] q [$]);
    return q[q.size() - 1];
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
    map_page(32'h0040_1000, 20'h12345, 5'b00011);   // read/write
    map_page(32'h0040_2000, 20'h0ABCD, 5'b00001);   // read only
    map_page(32'h0080_3000, 20'h55555, 5'b11101);   // read/exec, a and d preset
    map_page(32'h00C0_1000, 20'h00777, 5'b00001);   // makes level-2 table for l1=3
    for (int i = 0; i < 18; i++)
      map_page(32'h0010_0000 + 32'(i) * 32'h1000, 20'h80000 + 20'(i), 5'b00011);

    repeat (3) @(posedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R2 ready after reset", 32'(req_ready_o), 32'h1);
    chk("R2 no response after reset", 32'(rsp_valid_o), 32'h0);
    chk("R11 no read after reset", 32'(mem_req_o), 32'h0);

    xlat(32'h0040_1ABC, 2'd0, "R3 R1 miss walk");
    xlat(32'h0040_1004, 2'd0, "R2 R7 hit");
    xlat(32'h0040_1008, 2'd1, "R8 write sets dirty");
    xlat(32'h0040_1FFF, 2'd0, "R8 dirty kept");
    xlat(32'h0040_1000, 2'd2, "R6 exec denied hit");
    xlat(32'h0040_1000, 2'd3, "R6 reserved code");
    xlat(32'h7FC0_0000, 2'd0, "R5 level1 invalid");
    xlat(32'h7FC0_0010, 2'd0, "R5 no fill walks again");
    xlat(32'h00C0_5000, 2'd0, "R5 level2 invalid");
    xlat(32'h0040_2010, 2'd1, "R6 R8 write denied walk");
    xlat(32'h0040_2020, 2'd0, "R7 R8 refilled after prot fault");
    xlat(32'h0080_3123, 2'd2, "R4 preset flags exec");

    // back-to-back hits
    model(32'h0040_1010, 2'd0);
    @(negedge clk);
    req_valid_i = 1; req_vaddr_i = 32'h0040_1010; req_acc_i = 2'd0;
    @(negedge clk);
    chk("R2 back-to-back first valid", 32'(rsp_valid_o), 32'h1);
    chk("R2 back-to-back first paddr", rsp_paddr_o, e_pa);
    model(32'h0080_3456, 2'd0);
    req_vaddr_i = 32'h0080_3456;
    @(negedge clk);
    req_valid_i = 0;
    chk("R2 back-to-back second valid", 32'(rsp_valid_o), 32'h1);
    chk("R2 R1 back-to-back second paddr", rsp_paddr_o, e_pa);

    do_flush();
    xlat(32'h0040_1000, 2'd0, "R10 miss after flush");
    do_flush();

    for (int i = 0; i < 16; i++) xlat(32'h0010_0000 + 32'(i) * 32'h1000, 2'd0, "R9 fill free");
    for (int i = 0; i < 16; i++) xlat(32'h0010_0000 + 32'(i) * 32'h1000 + 32'h4, 2'd0, "R9 all held");
    xlat(32'h0011_0000, 2'd0, "R9 evict rr0");
    xlat(32'h0010_1000, 2'd0, "R9 entry1 still held");
    xlat(32'h0010_0000, 2'd0, "R9 evicted page walks");
    xlat(32'h0010_1000, 2'd0, "R9 rr moved on");
    xlat(32'h0011_1000, 2'd1, "R9 R8 write on refill");

    chk("R11 single outstanding read", 32'(mem_viol), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule